// File: doc/BRIEF.md
# Timer Input Capture Channel

This channel watches one external digital input and, when a chosen transition appears on it, stores the value of a free-running timer counter that is supplied from outside. The input first passes through a short synchronizer clocked by the peripheral clock. The transitions it reports therefore reach the capture register a fixed number of cycles after they appear at the pin. Software picks which transitions count: rising, falling, both or none.

Two power-of-two dividers thin out the events. The first lets only every Nth qualifying transition cause a capture. The second raises the interrupt flag only on every Mth capture. The channel runs without any help from the processor and reports three sticky status bits. The first says that a fresh value is waiting. The second says that a value was overwritten before it was read. The third is the interrupt request. A read strobe clears the first two, and a write-one-to-clear strobe clears the third. Dropping the enable input stops all captures and returns both dividers to their starting count.

Top module: `icap_channel`

## Requirements
- R1: After a synchronous reset, cap_val is zero and cap_ready, overcap and irq_flag are low.
- R2: edge_mode selects the qualifying transitions: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none (no capture ever happens).
- R3: A qualifying transition on sig_in is first sampled at some rising clock edge. cap_val then takes the timer_cnt value present at the third rising edge, counting that first one. With a counter that steps once per cycle, this is the count present when the new level was applied, plus 2.
- R4: With edge_div = k (0 to 3), a capture happens on every 2^k-th qualifying transition, counted from enable or from the previous capture.
- R5: With irq_div = k (0 to 3), irq_flag is set on every 2^k-th capture, counted from enable or from the previous interrupt.
- R6: A capture sets cap_ready. A one-cycle cap_rd pulse clears cap_ready and overcap, unless a capture happens in the same cycle, in which case cap_ready stays set.
- R7: A capture that occurs while cap_ready is set, with no cap_rd in that cycle, sets overcap and still overwrites cap_val.
- R8: irq_flag stays set until a cycle with irq_clr high. A new interrupt in that same cycle wins.
- R9: While enable is low, no capture or interrupt occurs and both dividers return to zero. Transitions seen while disabled are not counted after enable rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; low clears both dividers |
| edge_mode | input | 2 | Qualifying transition select (see R2) |
| edge_div | input | DIV_CODE_W | Edge prescaler code, divide by 2^code |
| irq_div | input | DIV_CODE_W | Interrupt prescaler code, divide by 2^code |
| sig_in | input | 1 | Asynchronous input being watched |
| timer_cnt | input | CNT_W | Free-running timer count |
| cap_rd | input | 1 | Read strobe for the capture register |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_flag |
| cap_val | output | CNT_W | Last captured timer value |
| cap_ready | output | 1 | A captured value is waiting to be read |
| overcap | output | 1 | A value was overwritten before it was read |
| irq_flag | output | 1 | Interrupt request |

## Verification
The state hardest to reach from the ports is a capture or interrupt landing after a long run of divided events. This needs up to 8 qualifying transitions, then up to 8 captures, with no disable in between and each transition spaced out so that the synchronizer drains. The stimulus drives a long random run of toggles, reads, clears and reconfigurations, and applies every setting change only while the channel is disabled, so that the bench model can follow both divider counts. Directed cases then force the 8-edge capture, the overwrite of an unread value, the "none" select, and transitions made while disabled.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic ready;
        logic ovr;
        logic irq;
    } cap_flags_t;

    function automatic logic edge_qualifies(edge_mode_e mode, logic rise, logic fall);
        return (mode[0] & rise) | (mode[1] & fall);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= sig_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= 1'b0;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] &  pipe[STAGES];

endmodule

// File: rtl/icap_div.sv
module icap_div #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    input  logic              tick,
    output logic              fire
);
    localparam int CW = (1 << CODE_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'((32'd1 << code) - 32'd1);
    assign fire = tick && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= fire ? '0 : cnt + 1'b1;
    end

    // R9
    div_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CODE_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [1:0]            edge_mode,
    input  logic [DIV_CODE_W-1:0] edge_div,
    input  logic [DIV_CODE_W-1:0] irq_div,
    input  logic                  sig_in,
    input  logic [CNT_W-1:0]      timer_cnt,
    input  logic                  cap_rd,
    input  logic                  irq_clr,
    output logic [CNT_W-1:0]      cap_val,
    output logic                  cap_ready,
    output logic                  overcap,
    output logic                  irq_flag
);
    import icap_pkg::*;

    logic       rise, fall;
    logic       edge_hit;
    logic       cap_stb;
    logic       irq_stb;
    cap_flags_t flags;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sig_in),
        .rise   (rise),
        .fall   (fall)
    );

    assign edge_hit = enable & edge_qualifies(edge_mode_e'(edge_mode), rise, fall);

    icap_div #(.CODE_W(DIV_CODE_W)) u_edge_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (~enable),
        .code (edge_div),
        .tick (edge_hit),
        .fire (cap_stb)
    );

    icap_div #(.CODE_W(DIV_CODE_W)) u_irq_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (~enable),
        .code (irq_div),
        .tick (cap_stb),
        .fire (irq_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
            flags   <= '0;
        end else begin
            if (cap_stb) cap_val <= timer_cnt;

            if (cap_stb)     flags.ready <= 1'b1;
            else if (cap_rd) flags.ready <= 1'b0;

            if (cap_stb && flags.ready && !cap_rd) flags.ovr <= 1'b1;
            else if (cap_rd)                       flags.ovr <= 1'b0;

            if (irq_stb)      flags.irq <= 1'b1;
            else if (irq_clr) flags.irq <= 1'b0;
        end
    end

    assign cap_ready = flags.ready;
    assign overcap   = flags.ovr;
    assign irq_flag  = flags.irq;

    // R6
    cap_ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> cap_ready);

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(cap_val));

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(cap_val) && !$rose(irq_flag)));

    // R5
    irq_needs_cap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> cap_ready);

    // R7
    ovr_prior_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overcap) |-> $past(cap_ready));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [1:0]       edge_mode = 2'b00;
    logic [1:0]       edge_div = 2'b00;
    logic [1:0]       irq_div = 2'b00;
    logic             sig_in = 1'b0;
    logic [CNT_W-1:0] timer_cnt = '0;
    logic             cap_rd = 1'b0;
    logic             irq_clr = 1'b0;
    logic [CNT_W-1:0] cap_val;
    logic             cap_ready;
    logic             overcap;
    logic             irq_flag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // bench model state
    logic [CNT_W-1:0] m_val = '0;
    bit m_ready = 0, m_ovr = 0, m_irq = 0;
    int m_ecnt = 0, m_ccnt = 0;

    icap_channel #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .edge_mode(edge_mode),
        .edge_div(edge_div), .irq_div(irq_div), .sig_in(sig_in),
        .timer_cnt(timer_cnt), .cap_rd(cap_rd), .irq_clr(irq_clr),
        .cap_val(cap_val), .cap_ready(cap_ready), .overcap(overcap),
        .irq_flag(irq_flag)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) timer_cnt <= timer_cnt + 1'b1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string vtag);
        check(vtag, 32'(cap_val), 32'(m_val));
        check("R6 ready", 32'(cap_ready), 32'(m_ready));
        check("R7 overcap", 32'(overcap), 32'(m_ovr));
        check("R5 irq", 32'(irq_flag), 32'(m_irq));
    endtask

    // called at a negedge; applies a level and updates the model
    task automatic drive_level(logic v, string vtag);
        logic old;
        logic [CNT_W-1:0] stamp;
        bit qual;
        old = sig_in;
        stamp = timer_cnt;
        sig_in = v;
        qual = enable && ((edge_mode[0] && v && !old) || (edge_mode[1] && !v && old));
        if (qual) begin
            m_ecnt++;
            if (m_ecnt >= (1 << edge_div)) begin
                m_ecnt = 0;
                if (m_ready) m_ovr = 1;
                m_ready = 1;
                m_val = stamp + 16'd2;
                m_ccnt++;
                if (m_ccnt >= (1 << irq_div)) begin
                    m_ccnt = 0;
                    m_irq = 1;
                end
            end
        end
        repeat (4) @(negedge clk);
        check_all(vtag);
    endtask

    task automatic do_read();
        check("R3 readout", 32'(cap_val), 32'(m_val));
        cap_rd = 1'b1;
        @(negedge clk);
        cap_rd = 1'b0;
        m_ready = 0;
        m_ovr = 0;
        @(negedge clk);
        check("R6 read clears ready", 32'(cap_ready), 32'(m_ready));
        check("R6 read clears overcap", 32'(overcap), 32'(m_ovr));
    endtask

    task automatic do_irq_clear();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        m_irq = 0;
        @(negedge clk);
        check("R8 irq clear", 32'(irq_flag), 32'(m_irq));
        check("R8 ready untouched", 32'(cap_ready), 32'(m_ready));
    endtask

    task automatic reconfig(logic [1:0] md, logic [1:0] ed, logic [1:0] idv);
        enable = 1'b0;
        @(negedge clk);
        edge_mode = md;
        edge_div = ed;
        irq_div = idv;
        m_ecnt = 0;
        m_ccnt = 0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int seed;
        int r;
        seed = 20240611;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cap_val", 32'(cap_val), 0);
        check("R1 cap_ready", 32'(cap_ready), 0);
        check("R1 overcap", 32'(overcap), 0);
        check("R1 irq_flag", 32'(irq_flag), 0);

        // R3 latency, both edges, no division
        reconfig(2'b11, 2'b00, 2'b00);
        drive_level(1'b1, "R3 rise latency");
        do_read();
        do_irq_clear();
        drive_level(1'b0, "R3 fall latency");
        do_read();
        do_irq_clear();

        // R2 none select, rising only, falling only
        reconfig(2'b00, 2'b00, 2'b00);
        drive_level(1'b1, "R2 none rise");
        drive_level(1'b0, "R2 none fall");
        reconfig(2'b01, 2'b00, 2'b00);
        drive_level(1'b1, "R2 rise-only rise");
        do_read();
        do_irq_clear();
        drive_level(1'b0, "R2 rise-only fall");
        reconfig(2'b10, 2'b00, 2'b00);
        drive_level(1'b1, "R2 fall-only rise");
        drive_level(1'b0, "R2 fall-only fall");

        // R7 overcapture: second capture without a read
        drive_level(1'b1, "R7 setup");
        drive_level(1'b0, "R7 overwrite");
        check("R7 overcap set", 32'(overcap), 1);
        do_read();
        do_irq_clear();

        // R4 divide by 8, R5 interrupt every 2nd capture
        reconfig(2'b01, 2'b11, 2'b01);
        for (int i = 0; i < 16; i++) begin
            drive_level(1'b1, "R4 div8");
            drive_level(1'b0, "R4 div8");
        end
        check("R5 irq after 2 captures", 32'(irq_flag), 1);
        do_read();
        do_irq_clear();

        // R9 divider reset by disable, edges while disabled ignored
        reconfig(2'b11, 2'b01, 2'b00);
        drive_level(1'b1, "R9 first of two");
        enable = 1'b0;
        m_ecnt = 0;
        m_ccnt = 0;
        @(negedge clk);
        drive_level(1'b0, "R9 edge while disabled");
        drive_level(1'b1, "R9 edge while disabled");
        enable = 1'b1;
        @(negedge clk);
        drive_level(1'b0, "R9 first after enable");
        check("R9 no capture yet", 32'(cap_ready), 0);
        drive_level(1'b1, "R9 second after enable");
        do_read();
        do_irq_clear();

        // random mix
        for (int it = 0; it < 400; it++) begin
            r = $urandom % 10;
            if (r < 7)       drive_level(~sig_in, "R3 random");
            else if (r == 7) do_read();
            else if (r == 8) do_irq_clear();
            else reconfig(2'($urandom), 2'($urandom), 2'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule